// File: doc/BRIEF.md
# Looping Descriptor-Ring Audio DMA Channel

This block is one DMA channel that streams audio samples between a circular buffer in memory and a single fixed peripheral data word, such as the transmit or receive word of a serial audio port. Software builds a ring of link descriptors in memory, one descriptor per buffer period, with the last one pointing back to the first. It programs the mode register and the ring base, then writes the start bit. From then on the channel walks the ring without further software action. It raises an end-of-segment interrupt after every period, so software can refill or drain the period just finished.

One side of every transfer is held at the peripheral word and the other side steps through memory. The held address is shifted to the byte lane that matches the beat size, so that narrow samples land in the low-order end of a big-endian 32-bit register. Bursts can be paced by a request line from the peripheral: before each burst the channel waits for the line, then moves a power-of-two number of bytes without looking at it again. Descriptor faults and bus errors stop the channel and are reported in a write-one-to-clear status register. The current source and destination addresses are readable at any time, so software can compute the stream position.

Control is a state machine with these states: `S_IDLE` (stopped), `S_FETCH` (four 64-bit descriptor reads), `S_CHECK` (validate the descriptor and load the beat pointers), `S_WAIT` (wait for the pacing line before a burst), `S_READ` (source beat), `S_WRITE` (destination beat), `S_SEGEND` (raise end-of-segment and follow the next pointer) and `S_HALT` (stopped on an error). The transitions are:
- `S_IDLE` or `S_HALT` to `S_FETCH` on start.
- `S_FETCH` to `S_CHECK` after the fourth word.
- `S_CHECK` to `S_WAIT` for a good descriptor, or to `S_HALT` for a bad one.
- `S_WAIT` to `S_READ` when pacing allows.
- `S_READ` to `S_WRITE`.
- `S_WRITE` to `S_SEGEND` when the count is exhausted, to `S_WAIT` when the burst is used up, and otherwise back to `S_READ`.
- `S_SEGEND` to `S_FETCH`.
- Any memory state to `S_HALT` on a bus error.
- Any state to `S_IDLE` on abort.

Top module: `adma_chan`

## Requirements
- R1: After reset the status register (word 1) reads 0, `irq` is low, `mem_req` is low, and the current-address registers (words 4 to 7) read 0 until the first data beat.
- R2: Writing the mode register (word 0) with bit 0 set starts the channel at the ring base (word 2 low 32 bits, word 3 bits [3:0] upper address bits). A descriptor is four little-endian 64-bit words at offsets 0, 8, 16 and 24: source address, destination address, next pointer (bits [35:0] of each), and byte count (bits [31:0]). After a segment the channel loads the descriptor at the next pointer and loops over the ring forever. Word 8 reads the remaining byte count of the current segment.
- R3: At the end of every segment, status bit 0 is set, and `irq` rises when mode bit 2 is set.
- R4: With mode bit 5 set, every write goes to the same held destination. With mode bit 4 set, every read comes from the same held source. The other side steps by the beat size.
- R5: Mode bits [7:6] select the beat size: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. Data travels in the low-order bytes of the 64-bit bus, and `mem_size` carries the same code.
- R6: The held address is the descriptor address plus 3 for 1-byte beats, plus 2 for 2-byte beats, and plus 0 for 4-byte and 8-byte beats.
- R7: With mode bit 12 set, the channel waits for `ext_req` high before each burst of 2^(mode bits [11:8]) bytes, and makes no data beat while it waits. With bit 12 clear it never waits.
- R8: Status bits 0 (end of segment), 1 (programming error) and 2 (transfer error) clear when a 1 is written to them. Writing 0 has no effect. Bit 3 (busy) and bit 4 (halted) are read-only.
- R9: A descriptor with a zero byte count, or with next-pointer bits [4:0] not zero, sets status bit 1 and halts the channel before any data beat.
- R10: Status bits 1 and 2 drive `irq` only while mode bit 3 is set.
- R11: A bus error response sets status bit 2, halts the channel and clears busy. The current-address register keeps the address of the failing beat.
- R12: Writing mode bit 1 aborts any activity; busy is low on the next cycle.
- R13: Current source and destination addresses are 36 bits wide. Words 4 and 6 hold the low 32 bits, and words 5 and 7 hold bits [35:32].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ext_req | input | 1 | Peripheral burst request / pacing line |
| mem_req | output | 1 | Memory access request, held until ready |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | 36 | Byte address of the access |
| mem_size | output | 2 | Access size code (bytes = 2^code) |
| mem_wdata | output | 64 | Write data, low-order bytes used |
| mem_rdata | input | 64 | Read data, low-order bytes valid |
| mem_ready | input | 1 | Access complete |
| mem_err | input | 1 | Error response, valid with ready |
| irq | output | 1 | Channel interrupt |

## Verification
The hardest situations to reach are the ring wrap, where a third period must reuse the first descriptor, and a bus error on a beat in the middle of a segment. For the wrap, the bench holds the pacing line low and raises it for one period at a time. It releases the line on each interrupt, so every segment end is seen and cleared in turn while the scoreboard follows the wrapped data. For the error case, the memory model answers one chosen address with an error response, after one good beat has already been written. Descriptor faults are placed in memory directly, and the scoreboard's empty queue exposes any data beat that the faulty descriptor would let through.

// File: rtl/adma_pkg.sv
package adma_pkg;

    localparam int REG_AW = 4;

    localparam logic [REG_AW-1:0] RA_MODE   = 4'd0;
    localparam logic [REG_AW-1:0] RA_STAT   = 4'd1;
    localparam logic [REG_AW-1:0] RA_BASE_L = 4'd2;
    localparam logic [REG_AW-1:0] RA_BASE_H = 4'd3;
    localparam logic [REG_AW-1:0] RA_CSRC_L = 4'd4;
    localparam logic [REG_AW-1:0] RA_CSRC_H = 4'd5;
    localparam logic [REG_AW-1:0] RA_CDST_L = 4'd6;
    localparam logic [REG_AW-1:0] RA_CDST_H = 4'd7;
    localparam logic [REG_AW-1:0] RA_REMAIN = 4'd8;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_CHECK, S_WAIT, S_READ, S_WRITE, S_SEGEND, S_HALT
    } chan_state_t;

    // stored mode fields, register bits [12:2]
    typedef struct packed {
        logic       pause_en;
        logic [3:0] bwc_lg;
        logic [1:0] hsize;
        logic       dst_hold;
        logic       src_hold;
        logic       err_ie;
        logic       eos_ie;
    } mode_t;

    function automatic logic [3:0] beat_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

    // byte lane inside a big-endian 32-bit word for narrow beats
    function automatic logic [1:0] lane_offset(input logic [1:0] code);
        unique case (code)
            2'd0:    return 2'd3;
            2'd1:    return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/adma_regs.sv
module adma_regs
    import adma_pkg::*;
#(
    parameter int AW = 36,
    parameter int CW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              ev_eos,
    input  logic              ev_pe,
    input  logic              ev_te,
    input  logic              busy,
    input  logic              halted,
    input  logic [AW-1:0]     cur_src,
    input  logic [AW-1:0]     cur_dst,
    input  logic [CW-1:0]     remain,
    output mode_t             mode,
    output logic              go,
    output logic              abort,
    output logic [AW-1:0]     ring_base,
    output logic              irq,
    output logic              eos_st,
    output logic              pe_st,
    output logic              te_st
);

    logic wr_mode, wr_stat, wr_bl, wr_bh;

    assign wr_mode = reg_wr && (reg_addr == RA_MODE);
    assign wr_stat = reg_wr && (reg_addr == RA_STAT);
    assign wr_bl   = reg_wr && (reg_addr == RA_BASE_L);
    assign wr_bh   = reg_wr && (reg_addr == RA_BASE_H);
    assign go      = wr_mode && reg_wdata[0];
    assign abort   = wr_mode && reg_wdata[1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode      <= '0;
            ring_base <= '0;
            eos_st    <= 1'b0;
            pe_st     <= 1'b0;
            te_st     <= 1'b0;
        end else begin
            if (wr_mode) mode <= mode_t'(reg_wdata[12:2]);
            if (wr_bl)   ring_base[31:0]  <= reg_wdata[31:0];
            if (wr_bh)   ring_base[AW-1:32] <= reg_wdata[AW-33:0];
            // events win over a clear in the same cycle
            eos_st <= (eos_st & ~(wr_stat & reg_wdata[0])) | ev_eos;
            pe_st  <= (pe_st  & ~(wr_stat & reg_wdata[1])) | ev_pe;
            te_st  <= (te_st  & ~(wr_stat & reg_wdata[2])) | ev_te;
        end
    end

    assign irq = (eos_st & mode.eos_ie) | ((pe_st | te_st) & mode.err_ie);

    always_comb begin
        unique case (reg_addr)
            RA_MODE:   reg_rdata = {19'd0, mode, 2'b00};
            RA_STAT:   reg_rdata = {27'd0, halted, busy, te_st, pe_st, eos_st};
            RA_BASE_L: reg_rdata = ring_base[31:0];
            RA_BASE_H: reg_rdata = 32'(ring_base[AW-1:32]);
            RA_CSRC_L: reg_rdata = cur_src[31:0];
            RA_CSRC_H: reg_rdata = 32'(cur_src[AW-1:32]);
            RA_CDST_L: reg_rdata = cur_dst[31:0];
            RA_CDST_H: reg_rdata = 32'(cur_dst[AW-1:32]);
            RA_REMAIN: reg_rdata = 32'(remain);
            default:   reg_rdata = 32'd0;
        endcase
    end

endmodule

// File: rtl/adma_lane.sv
module adma_lane
    import adma_pkg::*;
#(
    parameter int AW = 36
) (
    input  logic [1:0]    hsize,
    input  logic          src_hold,
    input  logic          dst_hold,
    input  logic [AW-1:0] d_src,
    input  logic [AW-1:0] d_dst,
    output logic [AW-1:0] src_start,
    output logic [AW-1:0] dst_start,
    output logic [AW-1:0] src_step,
    output logic [AW-1:0] dst_step
);

    logic [AW-1:0] off, step;

    assign off       = AW'(lane_offset(hsize));
    assign step      = AW'(beat_bytes(hsize));
    assign src_start = src_hold ? d_src + off : d_src;
    assign dst_start = dst_hold ? d_dst + off : d_dst;
    assign src_step  = src_hold ? '0 : step;
    assign dst_step  = dst_hold ? '0 : step;

endmodule

// File: rtl/adma_engine.sv
module adma_engine
    import adma_pkg::*;
#(
    parameter int AW      = 36,
    parameter int DW      = 64,
    parameter int CW      = 32,
    parameter int DESC_LG = 5,
    parameter int BURST_W = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mode_t         mode,
    input  logic          go,
    input  logic          abort,
    input  logic [AW-1:0] ring_base,
    input  logic          ext_req,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    input  logic          mem_err,
    output logic          ev_eos,
    output logic          ev_pe,
    output logic          ev_te,
    output logic          busy,
    output logic          halted,
    output logic [AW-1:0] cur_src,
    output logic [AW-1:0] cur_dst,
    output logic [CW-1:0] remain
);

    chan_state_t   state, state_nx;
    logic [1:0]    fidx;
    logic [AW-1:0] dptr, d_src, d_dst, d_next, src_p, dst_p;
    logic [AW-1:0] src_start, dst_start, src_step, dst_step;
    logic [CW-1:0] d_cnt;
    logic [BURST_W-1:0] burst_left;
    logic [DW-1:0] beat_data;
    logic [3:0]    bb;
    logic          done_ok, bad_desc, last_beat, burst_done, may_go;
    logic          unused_rd;

    assign unused_rd  = ^mem_rdata[DW-1:AW];
    assign bb         = beat_bytes(mode.hsize);
    assign done_ok    = mem_ready && !mem_err;
    assign bad_desc   = (d_cnt == '0) || (d_next[DESC_LG-1:0] != '0);
    assign last_beat  = remain <= CW'(bb);
    assign burst_done = burst_left <= BURST_W'(bb);
    assign may_go     = !mode.pause_en || ext_req;

    adma_lane #(.AW(AW)) u_lane (
        .hsize    (mode.hsize),
        .src_hold (mode.src_hold),
        .dst_hold (mode.dst_hold),
        .d_src    (d_src),
        .d_dst    (d_dst),
        .src_start(src_start),
        .dst_start(dst_start),
        .src_step (src_step),
        .dst_step (dst_step)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (go) state_nx = S_FETCH;
            S_FETCH:  if (mem_ready) state_nx = mem_err ? S_HALT :
                                                 (fidx == 2'd3) ? S_CHECK : S_FETCH;
            S_CHECK:  state_nx = bad_desc ? S_HALT : S_WAIT;
            S_WAIT:   if (may_go) state_nx = S_READ;
            S_READ:   if (mem_ready) state_nx = mem_err ? S_HALT : S_WRITE;
            S_WRITE:  if (mem_ready) state_nx = mem_err ? S_HALT :
                                                 last_beat ? S_SEGEND :
                                                 burst_done ? S_WAIT : S_READ;
            S_SEGEND: state_nx = S_FETCH;
            S_HALT:   if (go) state_nx = S_FETCH;
            default:  state_nx = S_IDLE;
        endcase
        if (abort) state_nx = S_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_size  = mode.hsize;
        mem_wdata = '0;
        unique case (state)
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = dptr + AW'({fidx, 3'b000});
                mem_size = 2'd3;
            end
            S_READ: begin
                mem_req  = 1'b1;
                mem_addr = src_p;
            end
            S_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_p;
                mem_wdata = beat_data;
            end
            default: ;
        endcase
        ev_eos = (state == S_SEGEND);
        ev_pe  = (state == S_CHECK) && bad_desc;
        ev_te  = mem_req && mem_ready && mem_err;
        busy   = (state != S_IDLE) && (state != S_HALT);
        halted = (state == S_HALT);
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fidx       <= '0;
            dptr       <= '0;
            d_src      <= '0;
            d_dst      <= '0;
            d_next     <= '0;
            d_cnt      <= '0;
            src_p      <= '0;
            dst_p      <= '0;
            remain     <= '0;
            burst_left <= '0;
            beat_data  <= '0;
            cur_src    <= '0;
            cur_dst    <= '0;
        end else begin
            unique case (state)
                S_IDLE, S_HALT: if (go) begin
                    dptr <= ring_base;
                    fidx <= '0;
                end
                S_FETCH: if (done_ok) begin
                    unique case (fidx)
                        2'd0: d_src  <= mem_rdata[AW-1:0];
                        2'd1: d_dst  <= mem_rdata[AW-1:0];
                        2'd2: d_next <= mem_rdata[AW-1:0];
                        default: d_cnt <= mem_rdata[CW-1:0];
                    endcase
                    fidx <= fidx + 2'd1;
                end
                S_CHECK: begin
                    src_p  <= src_start;
                    dst_p  <= dst_start;
                    remain <= d_cnt;
                end
                S_WAIT: if (may_go) burst_left <= BURST_W'(1) << mode.bwc_lg;
                S_READ: begin
                    cur_src <= src_p;
                    if (done_ok) beat_data <= mem_rdata;
                end
                S_WRITE: begin
                    cur_dst <= dst_p;
                    if (done_ok) begin
                        remain     <= remain - CW'(bb);
                        burst_left <= burst_left - BURST_W'(bb);
                        src_p      <= src_p + src_step;
                        dst_p      <= dst_p + dst_step;
                    end
                end
                S_SEGEND: begin
                    dptr <= d_next;
                    fidx <= '0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/adma_chan.sv
module adma_chan
    import adma_pkg::*;
#(
    parameter int AW      = 36,
    parameter int DW      = 64,
    parameter int CW      = 32,
    parameter int DESC_LG = 5,
    parameter int BURST_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              ext_req,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [1:0]        mem_size,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              mem_ready,
    input  logic              mem_err,
    output logic              irq
);

    mode_t         mode;
    logic          go, abort_p, busy_w, halted_w;
    logic          ev_eos, ev_pe, ev_te, eos_st, pe_st, te_st;
    logic [AW-1:0] ring_base, cur_src, cur_dst;
    logic [CW-1:0] remain;

    adma_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_eos(ev_eos), .ev_pe(ev_pe), .ev_te(ev_te),
        .busy(busy_w), .halted(halted_w),
        .cur_src(cur_src), .cur_dst(cur_dst), .remain(remain),
        .mode(mode), .go(go), .abort(abort_p), .ring_base(ring_base),
        .irq(irq), .eos_st(eos_st), .pe_st(pe_st), .te_st(te_st)
    );

    adma_engine #(.AW(AW), .DW(DW), .CW(CW), .DESC_LG(DESC_LG), .BURST_W(BURST_W)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .mode(mode), .go(go), .abort(abort_p), .ring_base(ring_base), .ext_req(ext_req),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready), .mem_err(mem_err),
        .ev_eos(ev_eos), .ev_pe(ev_pe), .ev_te(ev_te),
        .busy(busy_w), .halted(halted_w),
        .cur_src(cur_src), .cur_dst(cur_dst), .remain(remain)
    );

endmodule

// File: rtl/adma_chan_chk.sv
module adma_chan_chk #(
    parameter int AW = 36
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_ready,
    input logic          mem_err,
    input logic [AW-1:0] mem_addr,
    input logic          irq,
    input logic          abort_p,
    input logic          busy,
    input logic          halted,
    input logic          eos_st,
    input logic          pe_st,
    input logic          te_st,
    input logic          eos_ie
);

    // R2: a request stays put with the same address until it is answered
    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready && !abort_p) |=> (mem_req && $stable(mem_addr)));

    // R3: a new end-of-segment with its enable raises the interrupt
    a_r3_eos_irq: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(eos_st) && eos_ie) |-> irq);

    // R9: a programming error coincides with the halted state
    a_r9_pe_halts: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pe_st) |-> halted);

    // R11: a bus error halts the channel and drops busy
    a_r11_err_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && mem_err && !abort_p) |=> (halted && !busy && te_st));

    // R12: abort leaves the channel idle
    a_r12_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        abort_p |=> (!busy && !halted));

endmodule

bind adma_chan adma_chan_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .mem_req(mem_req), .mem_ready(mem_ready), .mem_err(mem_err), .mem_addr(mem_addr),
    .irq(irq), .abort_p(abort_p), .busy(busy_w), .halted(halted_w),
    .eos_st(eos_st), .pe_st(pe_st), .te_st(te_st), .eos_ie(mode.eos_ie)
);

// File: tb/adma_chan_test.sv
module adma_chan_test;

    localparam logic [31:0] M_GO = 32'h1, M_ABORT = 32'h2, M_EOSIE = 32'h4, M_ERRIE = 32'h8;
    localparam logic [31:0] M_SHOLD = 32'h10, M_DHOLD = 32'h20, M_PAUSE = 32'h1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ext_req = 1'b0;
    logic        mem_req, mem_we;
    logic [35:0] mem_addr;
    logic [1:0]  mem_size;
    logic [63:0] mem_wdata;
    logic [63:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic        mem_err = 1'b0;
    logic        irq;

    always #4 clk = ~clk;

    adma_chan uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_req(ext_req),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .mem_err(mem_err), .irq(irq)
    );

    typedef struct { logic [35:0] a; logic [63:0] d; } exp_t;
    exp_t exp_q[$];

    logic [7:0]  mem [logic [35:0]];
    logic [35:0] err_addr = 36'hF_FFFF_FFFF;
    logic [35:0] cap_addr = 36'hF_FFFF_FFF0;
    logic [7:0]  cap_val  = 8'd0;
    logic        watch = 1'b0;
    int          matched = 0;
    int          checks = 0;
    int          errors = 0;
    logic        done = 1'b0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // memory model and scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ready) begin
                mem_ready = 1'b0;
                mem_err   = 1'b0;
            end else if (mem_req) begin
                int n;
                logic [63:0] mask;
                n    = 1 << mem_size;
                mask = (n == 8) ? '1 : ((64'd1 << (8 * n)) - 64'd1);
                if (mem_addr == err_addr) begin
                    mem_err = 1'b1;
                end else if (!mem_we) begin
                    mem_rdata = '0;
                    if (mem_addr == cap_addr) begin
                        mem_rdata[7:0] = cap_val;
                        cap_val++;
                    end else begin
                        for (int i = 0; i < n; i++)
                            mem_rdata[8*i +: 8] = mem.exists(mem_addr + 36'(i)) ? mem[mem_addr + 36'(i)] : 8'h00;
                    end
                end else begin
                    for (int i = 0; i < n; i++) mem[mem_addr + 36'(i)] = mem_wdata[8*i +: 8];
                    if (watch) begin
                        if (exp_q.size() == 0) begin
                            check("R9 unexpected data beat", {28'd0, mem_addr}, 64'd0);
                        end else begin
                            exp_t e;
                            e = exp_q.pop_front();
                            check("R4/R5/R6 beat address", {28'd0, mem_addr}, {28'd0, e.a});
                            check("R5 beat data", mem_wdata & mask, e.d);
                            matched++;
                        end
                    end
                end
                mem_ready = 1'b1;
            end
        end
    end

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic put_word(input logic [35:0] a, input logic [63:0] w);
        for (int i = 0; i < 8; i++) mem[a + 36'(i)] = w[8*i +: 8];
    endtask

    task automatic put_desc(input logic [35:0] a, input logic [35:0] s, input logic [35:0] d,
                            input logic [35:0] nx, input logic [31:0] cnt);
        put_word(a,       {28'd0, s});
        put_word(a + 8,   {28'd0, d});
        put_word(a + 16,  {28'd0, nx});
        put_word(a + 24,  {32'd0, cnt});
    endtask

    task automatic push_exp(input logic [35:0] a, input logic [63:0] d);
        exp_t e;
        e.a = a; e.d = d;
        exp_q.push_back(e);
    endtask

    task automatic wait_irq(input string req);
        int t;
        t = 0;
        while (!irq && t < 3000) begin
            @(negedge clk);
            t++;
        end
        check(req, {63'd0, irq}, 64'd1);
    endtask

    task automatic start_ring(input logic [35:0] base, input logic [31:0] mode_v);
        reg_write(4'd2, base[31:0]);
        reg_write(4'd3, {28'd0, base[35:32]});
        reg_write(4'd0, mode_v | M_GO);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [35:0] buf_a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        reg_read(4'd1, r); check("R1 status after reset", {32'd0, r}, 64'd0);
        check("R1 irq after reset", {63'd0, irq}, 64'd0);
        check("R1 mem_req after reset", {63'd0, mem_req}, 64'd0);
        reg_read(4'd4, r); check("R1 cur src zero", {32'd0, r}, 64'd0);
        reg_read(4'd6, r); check("R1 cur dst zero", {32'd0, r}, 64'd0);

        // playback, 2-byte beats, held destination, paced one period at a time
        buf_a = 36'h3_0000_2000;
        for (int j = 0; j < 16; j++) mem[buf_a + 36'(j)] = 8'h10 + 8'(j);
        put_desc(36'h100, buf_a,     36'h1000, 36'h120, 32'd8);
        put_desc(36'h120, buf_a + 8, 36'h1000, 36'h100, 32'd8);
        for (int p = 0; p < 3; p++)
            for (int k = 0; k < 4; k++) begin
                int o;
                o = (p % 2) * 8 + 2 * k;
                push_exp(36'h1002, {48'd0, 8'h11 + 8'(o), 8'h10 + 8'(o)});
            end
        watch = 1'b1; matched = 0;
        start_ring(36'h100, M_EOSIE | M_ERRIE | M_DHOLD | (32'd1 << 6) | (32'd3 << 8) | M_PAUSE);
        repeat (30) @(negedge clk);
        reg_read(4'd1, r); check("R7 busy while waiting", {63'd0, r[3]}, 64'd1);
        reg_read(4'd4, r); check("R7 no beat while ext_req low", {32'd0, r}, 64'd0);
        reg_read(4'd8, r); check("R2 count loaded", {32'd0, r}, 64'd8);
        for (int p = 0; p < 3; p++) begin
            ext_req = 1'b1;
            wait_irq("R3 irq at segment end");
            ext_req = 1'b0;
            reg_read(4'd1, r); check("R3 eos status bit", {63'd0, r[0]}, 64'd1);
            reg_read(4'd4, r); check("R2 ring walk cur src", {32'd0, r}, {32'd0, 32'h2006 + 32'((p % 2) * 8)});
            reg_read(4'd5, r); check("R13 cur src upper bits", {32'd0, r}, 64'd3);
            reg_read(4'd6, r); check("R6 held dst +2", {32'd0, r}, 64'h1002);
            if (p == 0) begin
                reg_write(4'd1, 32'd0);
                reg_read(4'd1, r); check("R8 write 0 keeps eos", {63'd0, r[0]}, 64'd1);
            end
            reg_write(4'd1, 32'd1);
            @(negedge clk);
            check("R8 eos cleared, irq low", {63'd0, irq}, 64'd0);
        end
        reg_write(4'd0, M_ABORT);
        reg_read(4'd1, r); check("R12 busy low after abort", {63'd0, r[3]}, 64'd0);
        check("R2 wrapped beats matched", 64'(matched), 64'd12);
        check("R2 scoreboard drained", 64'(exp_q.size()), 64'd0);
        watch = 1'b0; exp_q.delete();

        // capture, 1-byte beats, held source, no pacing
        cap_addr = 36'h3003; cap_val = 8'hA0;
        put_desc(36'h200, 36'h3000, 36'h4000, 36'h220, 32'd4);
        put_desc(36'h220, 36'h3000, 36'h4010, 36'h200, 32'd4);
        for (int k = 0; k < 4; k++) push_exp(36'h4000 + 36'(k), 64'hA0 + 64'(k));
        for (int k = 0; k < 4; k++) push_exp(36'h4010 + 36'(k), 64'hA4 + 64'(k));
        for (int k = 0; k < 4; k++) push_exp(36'h4000 + 36'(k), 64'hA8 + 64'(k));
        watch = 1'b1; matched = 0;
        start_ring(36'h200, M_EOSIE | M_SHOLD);
        wait_irq("R3 capture first segment");
        reg_write(4'd1, 32'd1);
        wait_irq("R3 capture second segment");
        reg_read(4'd4, r); check("R6 held src +3", {32'd0, r}, 64'h3003);
        reg_write(4'd0, M_ABORT);
        watch = 1'b0;
        check("R4 capture beats matched", 64'(matched >= 8), 64'd1);
        exp_q.delete();
        reg_write(4'd1, 32'h7);

        // programming errors
        watch = 1'b1; matched = 0;
        put_desc(36'h300, 36'h6000, 36'h1000, 36'h320, 32'd0);
        start_ring(36'h300, M_DHOLD | (32'd2 << 6));
        repeat (20) @(negedge clk);
        reg_read(4'd1, r);
        check("R9 zero count sets pe", {63'd0, r[1]}, 64'd1);
        check("R9 zero count halts", {62'd0, r[4:3]}, 64'd2);
        check("R10 no irq without err_ie", {63'd0, irq}, 64'd0);
        reg_write(4'd0, M_ERRIE | M_DHOLD | (32'd2 << 6));
        @(negedge clk);
        check("R10 irq with err_ie", {63'd0, irq}, 64'd1);
        reg_write(4'd1, 32'h2);
        @(negedge clk);
        check("R8 pe cleared", {63'd0, irq}, 64'd0);
        put_desc(36'h340, 36'h6000, 36'h1000, 36'h344, 32'd4);
        start_ring(36'h340, M_ERRIE | M_DHOLD | (32'd2 << 6));
        repeat (20) @(negedge clk);
        reg_read(4'd1, r); check("R9 misaligned next sets pe", {63'd0, r[1]}, 64'd1);
        check("R9 no data beat", 64'(matched), 64'd0);
        watch = 1'b0;
        reg_write(4'd0, M_ABORT);
        reg_write(4'd1, 32'h7);

        // transfer error on the second read of a segment, 4-byte beats
        for (int j = 0; j < 8; j++) mem[36'h5000 + 36'(j)] = 8'h50 + 8'(j);
        put_desc(36'h400, 36'h5000, 36'h1000, 36'h420, 32'd8);
        put_desc(36'h420, 36'h5000, 36'h1000, 36'h400, 32'd8);
        push_exp(36'h1000, 64'h53525150);
        err_addr = 36'h5004;
        watch = 1'b1; matched = 0;
        start_ring(36'h400, M_ERRIE | M_DHOLD | (32'd2 << 6) | (32'd3 << 8));
        repeat (40) @(negedge clk);
        reg_read(4'd1, r);
        check("R11 te set", {63'd0, r[2]}, 64'd1);
        check("R11 halted and not busy", {62'd0, r[4:3]}, 64'd2);
        check("R11 irq on bus error", {63'd0, irq}, 64'd1);
        reg_read(4'd4, r); check("R11 failing address kept", {32'd0, r}, 64'h5004);
        check("R6 held dst +0 beat seen", 64'(matched), 64'd1);
        watch = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule